// File: doc/BRIEF.md
# SAR Conversion Sequencing Controller

This block sequences a 6-bit charge-redistribution successive-approximation converter from a single system clock. A free-running phase counter divides each sample period into eight system-clock cycles. The first cycle is the sample cycle, in which every bit's capacitor pair sits at common mode. The next six cycles resolve the code one bit per cycle, from the most significant bit down. The last cycle presents the finished code with a one-cycle valid pulse.

The comparator result arrives on a single input and is used only while the comparator-enable output is high. Each bit has its own capture strobe and its own result flip-flop. Each bit also has three switch lines:

- The supply line connects the upper-array capacitor to supply and the lower-array capacitor to ground.
- The common-mode line parks both capacitors at common mode.
- The ground line connects the upper capacitor to ground and the lower capacitor to supply.

The bench supplies the capacitor array and the comparator as a behavioural model.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit returns to the common-mode line, the result register clears to 0 and `valid_o` is low. The first cycle after `rst` falls is a sample cycle (`sh_o` high).
- R2: `sh_o` is high for exactly one cycle out of every 8 system-clock cycles, and it is low in the seven cycles that follow it.
- R3: Throughout every sample cycle, all six bits have `sw_cm_o` high, and both of their other switch lines are low.
- R4: For every bit, exactly one of `sw_sup_o[k]`, `sw_cm_o[k]` and `sw_gnd_o[k]` is high in every cycle.
- R5: In cycle n of a period, where n runs from 1 to 6 and the sample cycle is cycle 0, `cap_stb_o` equals `1 << (6-n)`. Bit 5 is therefore resolved first and bit 0 last. `cmp_en_o` is high exactly in these six cycles.
- R6: If `cmp_i` is high in the strobe cycle of bit k, then from the next cycle `result_o[k]` is 1 and `sw_gnd_o[k]` is high. If `cmp_i` is low, `result_o[k]` is 0 and `sw_sup_o[k]` is high.
- R7: `cmp_i` has no effect while `cmp_en_o` is low. The result held in cycle 7 is still present unchanged in the following sample cycle.
- R8: In cycle 7 of each period, `valid_o` is high for one cycle and `result_o` holds the complete 6-bit code. Every code from 0 to 63 is reproduced exactly for an ideal comparator.
- R9: Once a bit's switch line has been decided, it stays unchanged until the switches return to common mode for the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator decision, high when the sampled input exceeds the array level |
| sh_o | output | 1 | Sample/hold strobe, high during the sample cycle |
| cmp_en_o | output | 1 | Comparator enable |
| cap_stb_o | output | 6 | Per-bit capture strobe, one-hot while resolving |
| result_o | output | 6 | Result register, one flip-flop per bit |
| valid_o | output | 1 | One-cycle pulse with the complete code |
| sw_sup_o | output | 6 | Per bit: upper capacitor to supply, lower to ground |
| sw_cm_o | output | 6 | Per bit: both capacitors to common mode |
| sw_gnd_o | output | 6 | Per bit: upper capacitor to ground, lower to supply |

## Verification
The assertions check the following on every cycle:

- the one-of-three exclusivity of each bit's switch lines;
- the common-mode state during the sample strobe;
- the capture of the comparator value into both the result flip-flop and the switch line of the strobed bit;
- the stability of a decided switch;
- the ordering of the capture strobes into the valid pulse.

Only the bench's scenarios show that the strobe cycles land at the right offsets in the period and that all 64 codes are reproduced. The bench's comparator model reads the switch lines back as an array level, so these scenarios also show that the switch encoding really forms a binary search. They further show that a comparator held high outside the enable window never disturbs a finished code.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned SAR_BITS   = 6;
    localparam int unsigned SAR_PERIOD = 8;

    // Connection state of one bit's capacitor pair.
    typedef enum logic [1:0] {
        SW_MID = 2'd0,   // both arrays at common mode
        SW_SUP = 2'd1,   // upper to supply, lower to ground (bit decided 0)
        SW_GND = 2'd2    // upper to ground, lower to supply (bit decided 1)
    } sw_sel_e;

    typedef struct packed {
        logic sup;
        logic mid;
        logic gnd;
    } sw_lines_t;

    function automatic sw_lines_t decode_sw(input sw_sel_e s);
        sw_lines_t l;
        l = '{sup: 1'b0, mid: 1'b0, gnd: 1'b0};
        case (s)
            SW_SUP:  l.sup = 1'b1;
            SW_GND:  l.gnd = 1'b1;
            default: l.mid = 1'b1;
        endcase
        return l;
    endfunction

    function automatic sw_sel_e decide_sw(input logic above);
        return above ? SW_GND : SW_SUP;
    endfunction

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int unsigned NBITS  = 6,
    parameter int unsigned PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic             sh,
    output logic             cmp_en,
    output logic [NBITS-1:0] cap_stb,
    output logic             valid,
    output logic             clr_sw
);
    localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST_PH  = PW'(PERIOD - 1);
    localparam logic [PW-1:0] VALID_PH = PW'(NBITS + 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                  phase <= '0;
        else if (phase == LAST_PH) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    assign sh = (phase == '0);

    for (genvar k = 0; k < NBITS; k++) begin : g_stb
        assign cap_stb[k] = (phase == PW'(NBITS - k));
    end

    assign cmp_en = |cap_stb;
    assign valid  = (phase == VALID_PH);
    assign clr_sw = (phase == LAST_PH);

    // R2: the sample strobe never lasts longer than one cycle
    assert_sh_single_R2: assert property (@(posedge clk) disable iff (rst)
        sh |=> !sh);

    // R5: bit 5 is resolved first and bit 1 is followed by bit 0
    assert_msb_after_sample_R5: assert property (@(posedge clk) disable iff (rst)
        sh |=> cap_stb[NBITS-1]);
    assert_lsb_order_R5: assert property (@(posedge clk) disable iff (rst)
        cap_stb[1] |=> cap_stb[0]);

    // R8: the valid pulse follows the last capture
    assert_valid_after_lsb_R8: assert property (@(posedge clk) disable iff (rst)
        cap_stb[0] |=> valid);

endmodule

// File: rtl/sar_bit_slice.sv
module sar_bit_slice
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap,
    input  logic clr,
    input  logic cmp,
    output logic res,
    output logic sup,
    output logic mid,
    output logic gnd
);
    sw_sel_e   sel;
    sw_lines_t lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SW_MID;
            res <= 1'b0;
        end else if (cap) begin
            sel <= decide_sw(cmp);
            res <= cmp;
        end else if (clr) begin
            sel <= SW_MID;
        end
    end

    assign lines = decode_sw(sel);
    assign sup   = lines.sup;
    assign mid   = lines.mid;
    assign gnd   = lines.gnd;

    // R4: exactly one connection per bit
    assert_one_line_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({sup, mid, gnd}) == 1);

    // R6: the captured comparator value drives result and switch alike
    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        cap |=> (res == $past(cmp)) && (gnd == $past(cmp)) && (sup == !$past(cmp)));

    // R9: a decided switch holds until it is cleared
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!cap && !clr) |=> ($stable(sup) && $stable(gnd)));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_i,
    output logic                sh_o,
    output logic                cmp_en_o,
    output logic [SAR_BITS-1:0] cap_stb_o,
    output logic [SAR_BITS-1:0] result_o,
    output logic                valid_o,
    output logic [SAR_BITS-1:0] sw_sup_o,
    output logic [SAR_BITS-1:0] sw_cm_o,
    output logic [SAR_BITS-1:0] sw_gnd_o
);
    logic clr_sw;

    sar_phase_timer #(
        .NBITS  (SAR_BITS),
        .PERIOD (SAR_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .sh      (sh_o),
        .cmp_en  (cmp_en_o),
        .cap_stb (cap_stb_o),
        .valid   (valid_o),
        .clr_sw  (clr_sw)
    );

    for (genvar k = 0; k < SAR_BITS; k++) begin : g_bit
        sar_bit_slice u_slice (
            .clk (clk),
            .rst (rst),
            .cap (cap_stb_o[k]),
            .clr (clr_sw),
            .cmp (cmp_i),
            .res (result_o[k]),
            .sup (sw_sup_o[k]),
            .mid (sw_cm_o[k]),
            .gnd (sw_gnd_o[k])
        );
    end

    // R3: the whole array is at common mode while sampling
    assert_sample_cm_R3: assert property (@(posedge clk) disable iff (rst)
        sh_o |-> (&sw_cm_o));

    // R5: a capture strobe only fires with the comparator enabled
    assert_stb_en_R5: assert property (@(posedge clk) disable iff (rst)
        (|cap_stb_o) |-> (cmp_en_o && $onehot0(cap_stb_o)));

    // R7: the code is not touched between the valid pulse and the next sample
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> $stable(result_o));

    // R1: reset leaves every bit at common mode with a cleared code
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> ((&sw_cm_o) && (result_o == '0) && !valid_o));

endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp_i;
    logic          sh_o, cmp_en_o, valid_o;
    logic [NB-1:0] cap_stb_o, result_o, sw_sup_o, sw_cm_o, sw_gnd_o;
    int            vin = 0;
    int            n_run = 0, n_fail = 0;
    bit            done = 0;

    always #10 clk = ~clk;

    sar_seq_ctrl u_sar_seq_ctrl (
        .clk(clk), .rst(rst), .cmp_i(cmp_i), .sh_o(sh_o), .cmp_en_o(cmp_en_o),
        .cap_stb_o(cap_stb_o), .result_o(result_o), .valid_o(valid_o),
        .sw_sup_o(sw_sup_o), .sw_cm_o(sw_cm_o), .sw_gnd_o(sw_gnd_o)
    );

    // Ideal array and comparator: switches to ground count as decided ones.
    // Outside the enable window the comparator is forced high.
    always_comb begin
        int lvl;
        int trial;
        lvl = 0;
        trial = 0;
        for (int j = 0; j < NB; j++) begin
            if (sw_gnd_o[j])  lvl   += (1 << j);
            if (cap_stb_o[j]) trial  = (1 << j);
        end
        cmp_i = cmp_en_o ? (vin >= lvl + trial) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_lines(input string req);
        for (int k = 0; k < NB; k++)
            chk((32'(sw_sup_o[k]) + 32'(sw_cm_o[k]) + 32'(sw_gnd_o[k])) == 1, req,
                {sw_sup_o[k], sw_cm_o[k], sw_gnd_o[k]}, 1);
    endtask

    initial begin
        int prev;
        prev = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sw_cm_o == '1, "R1 switches at common mode", sw_cm_o, 63);
        chk(result_o == '0, "R1 result cleared", result_o, 0);
        chk(valid_o == 1'b0, "R1 valid low", valid_o, 0);
        rst = 1'b0;
        for (int v = 0; v < 64; v++) begin
            // cycle 0: sample
            chk(sh_o == 1'b1, "R2 sample strobe", sh_o, 1);
            chk(sw_cm_o == '1 && sw_sup_o == '0 && sw_gnd_o == '0,
                "R3 common mode while sampling", sw_cm_o, 63);
            chk(cmp_en_o == 1'b0, "R5 comparator off while sampling", cmp_en_o, 0);
            if (v > 0)
                chk(result_o == NB'(prev), "R7 code unchanged after valid", result_o, prev);
            vin = v;
            for (int p = 1; p < 8; p++) begin
                @(negedge clk);
                chk(sh_o == 1'b0, "R2 strobe low between samples", sh_o, 0);
                chk_lines("R4 one switch line");
                if (p <= NB) begin
                    chk(cap_stb_o == NB'(1 << (NB - p)), "R5 strobe order", cap_stb_o, 1 << (NB - p));
                    chk(cmp_en_o == 1'b1, "R5 comparator enabled", cmp_en_o, 1);
                end else begin
                    chk(cap_stb_o == '0, "R5 no strobe", cap_stb_o, 0);
                    chk(cmp_en_o == 1'b0, "R7 comparator off", cmp_en_o, 0);
                end
                if (p >= 2) begin
                    int k;
                    k = NB + 1 - p;
                    chk(result_o[k] == v[k], "R6 result bit", result_o[k], v[k]);
                    chk(sw_gnd_o[k] == v[k] && sw_sup_o[k] == !v[k],
                        "R6 switch follows decision", sw_gnd_o[k], v[k]);
                    // R9: higher bits keep their decided connection
                    for (int j = k + 1; j < NB; j++)
                        chk(sw_gnd_o[j] == v[j], "R9 decided switch held", sw_gnd_o[j], v[j]);
                end
            end
            // cycle 7
            chk(valid_o == 1'b1, "R8 valid pulse", valid_o, 1);
            chk(result_o == NB'(v), "R8 complete code", result_o, v);
            prev = v;
            @(negedge clk);
            chk(valid_o == 1'b0, "R8 valid one cycle", valid_o, 0);
        end
        // R1: a reset in mid-conversion returns to the initial state
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(sw_cm_o == '1, "R1 mid-run reset switches", sw_cm_o, 63);
        chk(result_o == '0, "R1 mid-run reset result", result_o, 0);
        rst = 1'b0;
        chk(sh_o == 1'b1, "R1 sample cycle after reset", sh_o, 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule